// File: doc/BRIEF.md
# Clock Stop and Power-Down Gating Controller

This block sits between a free-running source clock and a bank of clock outputs. It decides, for every output, whether the output runs, parks, or is switched off. Three asynchronous active-low pins request a stop: one for the peripheral group, one for the processor group and one driven by a clock-request line. A fourth pin requests power-down. Configuration inputs set the following for each output: an enable bit, a stop-group selector and, for differential outputs, a free-running flag. One global drive-mode bit chooses how a stopped differential pair parks.

The pins pass through two-flop synchronizers on the source clock. The run/park/off decision for each output is then stored in a register clocked on the falling edge of the source clock, so gating begins and ends only while the source clock is low. For each differential output the block produces the true level, the complement level and an output-enable. A deasserted enable stands for the external pull-down state, and the block holds both data lines low while it is deasserted. Single-ended outputs either follow the source clock or sit low. Every pin is a plain control or clock signal, so there is no valid/ready flow at this block's edge.

Top module: `clk_stop_ctrl`

## Requirements
- R1: A differential output whose enable bit is 0 shows oe=0, t=0 and c=0, and a single-ended output whose enable bit is 0 is low. This holds whatever the stop pins do.
- R2: An enabled output that is not stopped and not powered down runs. A differential output gives t equal to the source clock, c equal to its inverse and oe=1. A single-ended output follows the source clock.
- R3: A stopped, non-free-running differential output with drive mode 0 parks with t=1, c=0 and oe=1.
- R4: A stopped, non-free-running differential output with drive mode 1 is released: oe=0 with t=0 and c=0. In general, oe=0 always comes with t=0 and c=0.
- R5: An enabled differential output with its free-running flag set keeps running while its selected stop pin is low.
- R6: While power-down is low, every differential output shows oe=0, t=0 and c=0, and every single-ended output is low. This overrides enable and free-running.
- R7: Each output's 2-bit group selector picks the pin that can stop it: 0 selects the peripheral stop pin, 1 the processor stop pin, 2 the clock-request pin and 3 none. Pins that are not selected have no effect on that output. A stopped single-ended output is low.
- R8: A pin change is taken by two synchronizer flops on rising source edges. It reaches the outputs at the first falling edge after the second rising edge. Output state changes only at falling edges.
- R9: While reset is asserted, all outputs are off: oe=0, t=0, c=0 and single-ended outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock being distributed |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_stop_n | input | 1 | Peripheral group stop request, active low |
| proc_stop_n | input | 1 | Processor group stop request, active low |
| creq_stop_n | input | 1 | Clock-request stop, active low |
| pwrdn_n | input | 1 | Power-down request, active low |
| drive_park_low | input | 1 | Drive mode: 0 parks t high, 1 releases to pull-down |
| cfg_diff_en | input | N_DIFF | Per differential output enable |
| cfg_diff_free | input | N_DIFF | Per differential output free-running flag |
| cfg_diff_grp | input | 2*N_DIFF | Per differential output stop-group selector |
| cfg_se_en | input | N_SE | Per single-ended output enable |
| cfg_se_grp | input | 2*N_SE | Per single-ended output stop-group selector |
| dif_t | output | N_DIFF | Differential true levels |
| dif_c | output | N_DIFF | Differential complement levels |
| dif_oe | output | N_DIFF | Differential drive enables (0 = pull-down) |
| se_clk | output | N_SE | Single-ended clock outputs |

## Verification
Power-down and a group stop can reach the same output in the same falling-edge update, and either one may land on an output that is free-running or disabled. The bench sweeps all sixteen combinations of the four pins, changing them together in one step, under both drive modes and four configurations that rotate group selection and the enable and free-running flags. The outputs are sampled in both the high and the low clock phase. The expected levels follow the precedence power-down, then enable, then stop, then free-running, so a wrong priority shows up as a wrong level in one of the two phases. A separate step times a power-down edge against the synchronizer depth.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_PARKH = 2'd1,
    ST_RUN   = 2'd2
  } cs_state_e;

  localparam int GRP_W      = 2;
  localparam int N_PINS     = 4;
  localparam int PIN_PERIPH = 0;
  localparam int PIN_PROC   = 1;
  localparam int PIN_CREQ   = 2;
  localparam int PIN_PD     = 3;
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] s1_q, s2_q;

  // Reset to 0: every request reads as asserted until the pins are seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_async;
      s2_q <= s1_q;
    end
  end

  assign d_sync = s2_q;

  for (genvar k = 0; k < W; k++) begin : g_chk
    // R8
    sync_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(s2_q[k]) |-> $past(s1_q[k]));
    // R8
    sync_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(s2_q[k]) |-> !$past(s1_q[k]));
  end
endmodule

// File: rtl/cs_decide.sv
module cs_decide
  import clk_stop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pd_n_s,
  input  logic      stop_n_s,
  input  logic      en,
  input  logic      free,
  input  logic      park_low,
  output cs_state_e st
);
  cs_state_e st_d, st_q;

  always_comb begin
    if (!pd_n_s || !en)            st_d = ST_OFF;
    else if (!stop_n_s && !free)   st_d = park_low ? ST_OFF : ST_PARKH;
    else                           st_d = ST_RUN;
  end

  // Falling-edge update: gating only moves while the source clock is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  assign st = st_q;

  // R6
  pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n_s |-> st_q == ST_OFF);
  // R5
  free_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n_s && en && free && $stable(en) && $stable(free)) |-> st_q == ST_RUN);
  // R8
  hold_high_chk: assert property (@(negedge clk) disable iff (!rst_n)
    1'b1 |-> st_q == $past(st_d));
endmodule

// File: rtl/cs_drive.sv
module cs_drive
  import clk_stop_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cs_state_e st,
  output logic      t,
  output logic      c,
  output logic      oe
);
  always_comb begin
    unique case (st)
      ST_RUN:   begin t = clk;  c = ~clk; oe = 1'b1; end
      ST_PARKH: begin t = 1'b1; c = 1'b0; oe = 1'b1; end
      default:  begin t = 1'b0; c = 1'b0; oe = 1'b0; end
    endcase
  end

  // R4
  pulldown_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> (!t && !c));
  // R3
  pair_excl_chk: assert property (@(negedge clk) disable iff (!rst_n)
    !(t && c));
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int N_DIFF = 4,
  parameter int N_SE   = 2
) (
  input  logic                    clk_src,
  input  logic                    rst_n,
  input  logic                    periph_stop_n,
  input  logic                    proc_stop_n,
  input  logic                    creq_stop_n,
  input  logic                    pwrdn_n,
  input  logic                    drive_park_low,
  input  logic [N_DIFF-1:0]       cfg_diff_en,
  input  logic [N_DIFF-1:0]       cfg_diff_free,
  input  logic [GRP_W*N_DIFF-1:0] cfg_diff_grp,
  input  logic [N_SE-1:0]         cfg_se_en,
  input  logic [GRP_W*N_SE-1:0]   cfg_se_grp,
  output logic [N_DIFF-1:0]       dif_t,
  output logic [N_DIFF-1:0]       dif_c,
  output logic [N_DIFF-1:0]       dif_oe,
  output logic [N_SE-1:0]         se_clk
);
  logic [N_PINS-1:0] pins_async, pins_s;
  logic [3:0]        stop_vec;

  always_comb begin
    pins_async             = '0;
    pins_async[PIN_PERIPH] = periph_stop_n;
    pins_async[PIN_PROC]   = proc_stop_n;
    pins_async[PIN_CREQ]   = creq_stop_n;
    pins_async[PIN_PD]     = pwrdn_n;
  end

  cs_sync #(.W(N_PINS)) u_sync (
    .clk     (clk_src),
    .rst_n   (rst_n),
    .d_async (pins_async),
    .d_sync  (pins_s)
  );

  // R7: selector 3 maps to a never-asserted stop.
  assign stop_vec = {1'b1, pins_s[PIN_CREQ], pins_s[PIN_PROC], pins_s[PIN_PERIPH]};

  for (genvar i = 0; i < N_DIFF; i++) begin : g_diff
    cs_state_e st;
    logic      stop_n;
    assign stop_n = stop_vec[cfg_diff_grp[GRP_W*i +: GRP_W]];

    cs_decide u_dec (
      .clk      (clk_src),
      .rst_n    (rst_n),
      .pd_n_s   (pins_s[PIN_PD]),
      .stop_n_s (stop_n),
      .en       (cfg_diff_en[i]),
      .free     (cfg_diff_free[i]),
      .park_low (drive_park_low),
      .st       (st)
    );

    cs_drive u_drv (
      .clk   (clk_src),
      .rst_n (rst_n),
      .st    (st),
      .t     (dif_t[i]),
      .c     (dif_c[i]),
      .oe    (dif_oe[i])
    );
  end

  for (genvar k = 0; k < N_SE; k++) begin : g_se
    cs_state_e st;
    logic      stop_n;
    assign stop_n = stop_vec[cfg_se_grp[GRP_W*k +: GRP_W]];

    // Single-ended outputs never free-run; a park state reads as low.
    cs_decide u_dec (
      .clk      (clk_src),
      .rst_n    (rst_n),
      .pd_n_s   (pins_s[PIN_PD]),
      .stop_n_s (stop_n),
      .en       (cfg_se_en[k]),
      .free     (1'b0),
      .park_low (1'b1),
      .st       (st)
    );

    assign se_clk[k] = (st == ST_RUN) & clk_src;

    // R6
    se_pd_low_chk: assert property (@(posedge clk_src) disable iff (!rst_n)
      !pins_s[PIN_PD] |-> !se_clk[k]);
  end
endmodule

// File: tb/tb_clk_stop_ctrl.sv
module tb_clk_stop_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 4;
  localparam int NS = 2;

  logic clk_src = 1'b0;
  logic rst_n = 1'b0;
  logic periph_stop_n = 1'b1, proc_stop_n = 1'b1, creq_stop_n = 1'b1, pwrdn_n = 1'b1;
  logic drive_park_low = 1'b0;
  logic [ND-1:0]   cfg_diff_en = '1, cfg_diff_free = '0;
  logic [2*ND-1:0] cfg_diff_grp = '0;
  logic [NS-1:0]   cfg_se_en = '1;
  logic [2*NS-1:0] cfg_se_grp = '0;
  logic [ND-1:0]   dif_t, dif_c, dif_oe;
  logic [NS-1:0]   se_clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_src = ~clk_src;

  clk_stop_ctrl #(.N_DIFF(ND), .N_SE(NS)) dut (
    .clk_src, .rst_n, .periph_stop_n, .proc_stop_n, .creq_stop_n, .pwrdn_n,
    .drive_park_low, .cfg_diff_en, .cfg_diff_free, .cfg_diff_grp,
    .cfg_se_en, .cfg_se_grp, .dif_t, .dif_c, .dif_oe, .se_clk
  );

  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", rq, what, act, exp, $time);
    end
  endtask

  // pins: {pd, creq, proc, periph}; selector 3 = none
  function automatic logic stop_n_of(input int g, input logic [3:0] p);
    return (g == 3) ? 1'b1 : p[g];
  endfunction

  task automatic check_phase(input logic ph, input logic [3:0] p);
    for (int i = 0; i < ND; i++) begin
      int    g = int'(cfg_diff_grp[2*i +: 2]);
      logic  st_n = stop_n_of(g, p);
      logic  et, ec, eo;
      string rq;
      if (!p[3])                              begin et=0; ec=0; eo=0; rq="R6"; end
      else if (!cfg_diff_en[i])               begin et=0; ec=0; eo=0; rq="R1"; end
      else if (!st_n && !cfg_diff_free[i])
        if (drive_park_low)                   begin et=0; ec=0; eo=0; rq="R4"; end
        else                                  begin et=1; ec=0; eo=1; rq="R3"; end
      else if (!st_n)                         begin et=ph; ec=~ph; eo=1; rq="R5"; end
      else if (p[2:0] != 3'b111)              begin et=ph; ec=~ph; eo=1; rq="R7"; end
      else                                    begin et=ph; ec=~ph; eo=1; rq="R2"; end
      chk(rq, $sformatf("dif_t[%0d]", i), dif_t[i], et);
      chk(rq, $sformatf("dif_c[%0d]", i), dif_c[i], ec);
      chk(rq, $sformatf("dif_oe[%0d]", i), dif_oe[i], eo);
    end
    for (int k = 0; k < NS; k++) begin
      int    g = int'(cfg_se_grp[2*k +: 2]);
      logic  es;
      string rq;
      if (!p[3])                    begin es = 0;  rq = "R6"; end
      else if (!cfg_se_en[k])       begin es = 0;  rq = "R1"; end
      else if (!stop_n_of(g, p))    begin es = 0;  rq = "R7"; end
      else                          begin es = ph; rq = "R2"; end
      chk(rq, $sformatf("se_clk[%0d]", k), se_clk[k], es);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] p;
    // R9: reset state
    repeat (3) @(posedge clk_src);
    #2;
    for (int i = 0; i < ND; i++) begin
      chk("R9", "dif_oe in reset", dif_oe[i], 1'b0);
      chk("R9", "dif_t in reset",  dif_t[i],  1'b0);
      chk("R9", "dif_c in reset",  dif_c[i],  1'b0);
    end
    chk("R9", "se_clk in reset", se_clk[0], 1'b0);
    @(negedge clk_src); #1;
    rst_n = 1'b1;

    // Sweep: 4 configs x 2 drive modes x 16 pin patterns, both phases
    for (int c = 0; c < 4; c++) begin
      for (int dm = 0; dm < 2; dm++) begin
        for (int pv = 0; pv < 16; pv++) begin
          p = 4'(pv);
          @(negedge clk_src); #1;
          cfg_diff_en   = (c == 2) ? 4'b0101 : 4'b1111;
          cfg_diff_free = (c == 0) ? 4'b0000 : (c == 1) ? 4'b1010 :
                          (c == 2) ? 4'b0011 : 4'b1111;
          for (int i = 0; i < ND; i++) cfg_diff_grp[2*i +: 2] = 2'((i + c) % 4);
          cfg_se_en = (c == 1) ? 2'b01 : 2'b11;
          for (int k = 0; k < NS; k++) cfg_se_grp[2*k +: 2] = 2'((k + c + 1) % 4);
          drive_park_low = dm[0];
          periph_stop_n = p[0]; proc_stop_n = p[1]; creq_stop_n = p[2]; pwrdn_n = p[3];
          repeat (4) @(posedge clk_src);
          #2; check_phase(1'b1, p);
          @(negedge clk_src); #2; check_phase(1'b0, p);
        end
      end
    end

    // R8: latency of a power-down edge through the synchronizer
    @(negedge clk_src); #1;
    cfg_diff_en = '1; cfg_diff_free = '0; drive_park_low = 1'b0;
    periph_stop_n = 1; proc_stop_n = 1; creq_stop_n = 1; pwrdn_n = 1;
    repeat (4) @(posedge clk_src);
    @(negedge clk_src); #1;
    pwrdn_n = 1'b0;
    @(posedge clk_src); #2;
    chk("R8", "dif_t one rise after pd", dif_t[0], 1'b1);
    @(posedge clk_src); #2;
    chk("R8", "dif_t two rises after pd", dif_t[0], 1'b1);
    chk("R8", "dif_oe two rises after pd", dif_oe[0], 1'b1);
    @(posedge clk_src); #2;
    chk("R8", "dif_oe three rises after pd", dif_oe[0], 1'b0);
    chk("R8", "dif_t three rises after pd", dif_t[0], 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule